// File: doc/BRIEF.md
# Microcontroller interrupt controller

This block collects the interrupt requests of a small 8-bit microcontroller and turns them into one level-sensitive request line for the CPU core. Five sources are watched: a falling edge on any input-mode pin of an 8-pin port, a falling edge on any pin of a 5-pin port, underflow pulses from two timers, and a tick from a clock divider. Each event is latched into a status register. A per-source enable register gates it, and a global inhibit flag that the CPU controls masks the result.

The CPU writes the enable register and reads the status register at register address 0. At address 1 it writes a write-one-to-clear mask for the status register and reads back the enable register. Taking an interrupt (the acknowledge strobe) raises the inhibit at once. The inhibit falls again only on a clear-inhibit instruction or a write to the enable register. A watchdog-reset record sits in the top status bit, and it can be cleared only while a write-protect unlock input is high. The block also gives the address of the vector byte that the CPU fetches.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After reset the status and enable registers read 0x00, the inhibit is set, `irq` is low and `pd_bor` is low.
- R2: Status bit positions are: bit 1 for the 5-pin port edge, bit 2 for the 8-pin port edge, bit 3 for timer 0 underflow, bit 4 for timer 1 underflow and bit 5 for the divider tick. A one-cycle pulse on a timer or divider input sets its bit at the next clock edge. Bits 0 and 6 always read 0.
- R3: A falling edge on an 8-pin port pin whose `p0_is_input` bit is 1 sets status bit 2 on the third clock edge after the pin changes. Falling edges on pins with `p0_is_input` at 0, and rising edges, do not set it.
- R4: A falling edge on any of the five `p1_pins` sets status bit 1 on the third clock edge after the pin changes.
- R5: `irq` is high exactly when some bit n in 1..5 has both status and enable set and the inhibit is clear. Status bits latch even when their enable is 0.
- R6: `cpu_ack` or `cpu_sei` sets the inhibit. `cpu_cli` or a write to address 0 clears it. A set and a clear in the same cycle leave the inhibit set.
- R7: A write to address 1 clears each status bit 1..5 whose data bit is 1. Data bits at 0 leave their status bits unchanged.
- R8: When a hardware event and a clear write target the same status bit in the same cycle, the bit ends up set.
- R9: `wdt_event` sets status bit 7. A clear write with data bit 7 at 1 clears it only while `wdt_unlock` is high.
- R10: Enable bit 7 is stored, reads back at address 1 and drives `pd_bor`. It never affects `irq`. Enable bits 0 and 6 read 0.
- R11: `vec_addr` is 0xFFFE/0xFFFF (low/high byte chosen by `vec_high`) for the maskable interrupt and 0xFFFC/0xFFFD when `vec_reset` is 1.
- R12: Reads at address 0 return the status register and reads at address 1 return the enable register. The read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address: 0 enable/status, 1 clear/enable readback |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| p0_pins | input | 8 | 8-pin port levels (asynchronous) |
| p0_is_input | input | 8 | Per-pin input-mode flag for the 8-pin port |
| p1_pins | input | 5 | 5-pin port levels (asynchronous) |
| tmr0_uflow | input | 1 | Timer 0 underflow pulse |
| tmr1_uflow | input | 1 | Timer 1 underflow pulse |
| div_tick | input | 1 | Divider tick pulse |
| wdt_event | input | 1 | Watchdog reset record pulse |
| wdt_unlock | input | 1 | Write-protect unlock for status bit 7 clear |
| cpu_ack | input | 1 | Interrupt acknowledge strobe |
| cpu_sei | input | 1 | Set-inhibit instruction strobe |
| cpu_cli | input | 1 | Clear-inhibit instruction strobe |
| vec_reset | input | 1 | Selects the reset vector pair |
| vec_high | input | 1 | Selects the high byte of the vector pair |
| vec_addr | output | 16 | Vector byte address |
| irq | output | 1 | Level interrupt request to the CPU |
| pd_bor | output | 1 | Stored power-down brown-out control bit |

## Verification
The properties assume that the timer, divider and watchdog inputs are single-cycle pulses already in the core clock domain. They also assume that the port pins change at most once per clock, and that the CPU strobes are synchronous to the same clock. The random phase holds both ports idle high. It draws the pulses, strobes and register writes fresh each cycle at the falling clock edge, so every input is stable across the rising edge. The directed phase moves port pins one at a time and holds each level for at least three cycles, so every edge passes through the synchronizer.

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl #(
  parameter int          P0_W    = 8,
  parameter int          P1_W    = 5,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE,
  parameter logic [15:0] VEC_RST = 16'hFFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [P0_W-1:0] p0_pins,
  input  logic [P0_W-1:0] p0_is_input,
  input  logic [P1_W-1:0] p1_pins,
  input  logic            tmr0_uflow,
  input  logic            tmr1_uflow,
  input  logic            div_tick,
  input  logic            wdt_event,
  input  logic            wdt_unlock,
  input  logic            cpu_ack,
  input  logic            cpu_sei,
  input  logic            cpu_cli,
  input  logic            vec_reset,
  input  logic            vec_high,
  output logic [15:0]     vec_addr,
  output logic            irq,
  output logic            pd_bor
);
  localparam logic [7:0] EN_KEEP  = 8'hBE;
  localparam logic [7:0] CLR_KEEP = 8'h3E;

  logic [P0_W-1:0] p0_s1, p0_s2, p0_s3;
  logic [P1_W-1:0] p1_s1, p1_s2, p1_s3;
  logic [7:0]      status_q, enable_q;
  logic            inhibit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_s1 <= '1; p0_s2 <= '1; p0_s3 <= '1;
      p1_s1 <= '1; p1_s2 <= '1; p1_s3 <= '1;
    end else begin
      p0_s1 <= p0_pins; p0_s2 <= p0_s1; p0_s3 <= p0_s2;
      p1_s1 <= p1_pins; p1_s2 <= p1_s1; p1_s3 <= p1_s2;
    end
  end

  wire p0_fall = |(p0_s3 & ~p0_s2 & p0_is_input);
  wire p1_fall = |(p1_s3 & ~p1_s2);

  wire       wr_en  = bus_wr & ~bus_addr;
  wire       wr_clr = bus_wr &  bus_addr;
  wire [7:0] set_v  = {wdt_event, 1'b0, div_tick, tmr1_uflow, tmr0_uflow,
                       p0_fall, p1_fall, 1'b0};
  wire [7:0] clr_v  = wr_clr ? ((bus_wdata & CLR_KEEP) |
                                {bus_wdata[7] & wdt_unlock, 7'b0}) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= 8'h00;
      enable_q  <= 8'h00;
      inhibit_q <= 1'b1;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;
      if (wr_en) enable_q <= bus_wdata & EN_KEEP;
      if (cpu_ack | cpu_sei)     inhibit_q <= 1'b1;
      else if (cpu_cli | wr_en)  inhibit_q <= 1'b0;
    end
  end

  assign irq       = (|(status_q[5:1] & enable_q[5:1])) & ~inhibit_q;
  assign bus_rdata = bus_addr ? enable_q : status_q;
  assign pd_bor    = enable_q[7];
  assign vec_addr  = (vec_reset ? VEC_RST : VEC_IRQ) | {15'b0, vec_high};
endmodule

// File: rtl/mcu_irq_ctrl_sva.sv
module mcu_irq_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       tmr0_uflow,
  input logic       wdt_unlock,
  input logic       cpu_ack,
  input logic       irq,
  input logic [7:0] status,
  input logic [7:0] enable
);
  assert_tm0_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_uflow |=> status[3]);

  assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status[5:1] & enable[5:1]) != 5'd0));

  assert_ack_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !irq);

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && bus_wdata[3] && !tmr0_uflow) |=> !status[3]);

  assert_wdt_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wdt_unlock) |=> status[7]);
endmodule

bind mcu_irq_ctrl mcu_irq_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tmr0_uflow(tmr0_uflow), .wdt_unlock(wdt_unlock),
  .cpu_ack(cpu_ack), .irq(irq), .status(status_q), .enable(enable_q)
);

// File: tb/tb_mcu_irq_ctrl.sv
module tb_mcu_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] p0_pins = 8'hFF, p0_is_input = 8'h00;
  logic [4:0] p1_pins = 5'h1F;
  logic tmr0_uflow = 0, tmr1_uflow = 0, div_tick = 0, wdt_event = 0, wdt_unlock = 0;
  logic cpu_ack = 0, cpu_sei = 0, cpu_cli = 0, vec_reset = 0, vec_high = 0;
  logic [15:0] vec_addr;
  logic irq, pd_bor;
  int nvec = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mcu_irq_ctrl dut (.*);

  function automatic logic [7:0] next_status(logic [7:0] st, logic wr, logic a,
      logic [7:0] wd, logic unl, logic [7:0] setv);
    logic [7:0] clr = 8'h00;
    if (wr && a) clr = (wd & 8'h3E) | {wd[7] & unl, 7'b0};
    return (st & ~clr) | setv;
  endfunction

  function automatic logic exp_irq(logic [7:0] st, logic [7:0] en, logic inh);
    return (|(st[5:1] & en[5:1])) & ~inh;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(2); rst_n = 1; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v, st_m, en_m;
    logic inh_m;
    void'($urandom(32'h5EED1234));
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(0, v); chk("R1 status", 16'(v), 16'h00);
    rd(1, v); chk("R1 enable", 16'(v), 16'h00);
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 pd_bor", 16'(pd_bor), 16'h0);

    // random phase (ports idle high), R5 R6 R7 R8 R9 R10 R12
    st_m = 0; en_m = 0; inh_m = 1;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] setv;
      bus_wr     = ($urandom % 3) == 0;
      bus_addr   = $urandom % 2;
      bus_wdata  = 8'($urandom);
      tmr0_uflow = ($urandom % 5) == 0;
      tmr1_uflow = ($urandom % 5) == 0;
      div_tick   = ($urandom % 5) == 0;
      wdt_event  = ($urandom % 17) == 0;
      wdt_unlock = $urandom % 2;
      cpu_ack    = ($urandom % 7) == 0;
      cpu_sei    = ($urandom % 9) == 0;
      cpu_cli    = ($urandom % 4) == 0;
      setv = {wdt_event, 1'b0, div_tick, tmr1_uflow, tmr0_uflow, 3'b000};
      st_m = next_status(st_m, bus_wr, bus_addr, bus_wdata, wdt_unlock, setv);
      if (bus_wr && !bus_addr) en_m = bus_wdata & 8'hBE;
      if (cpu_ack || cpu_sei) inh_m = 1;
      else if (cpu_cli || (bus_wr && !bus_addr)) inh_m = 0;
      tick();
      bus_wr = 0; tmr0_uflow = 0; tmr1_uflow = 0; div_tick = 0; wdt_event = 0;
      cpu_ack = 0; cpu_sei = 0; cpu_cli = 0;
      rd(bus_addr, v);
      chk(bus_addr ? "R12 enable read" : "R7 R8 R9 status read", 16'(v),
          16'(bus_addr ? en_m : st_m));
      chk("R5 R6 R10 irq", 16'(irq), 16'(exp_irq(st_m, en_m, inh_m)));
      chk("R10 pd_bor", 16'(pd_bor), 16'(en_m[7]));
    end
    wdt_unlock = 0;

    // directed phase
    do_reset();
    tmr0_uflow = 1; tick(); tmr0_uflow = 0;
    rd(0, v); chk("R2 timer0 bit3", 16'(v), 16'h08);
    chk("R5 latched but disabled", 16'(irq), 16'h0);
    wr(0, 8'h08); chk("R6 enable write lifts inhibit", 16'(irq), 16'h1);
    cpu_ack = 1; tick(); cpu_ack = 0; chk("R6 ack inhibits", 16'(irq), 16'h0);
    cpu_cli = 1; tick(); cpu_cli = 0; chk("R6 cli lifts", 16'(irq), 16'h1);
    cpu_sei = 1; tick(); cpu_sei = 0; chk("R6 sei inhibits", 16'(irq), 16'h0);
    cpu_cli = 1; cpu_ack = 1; tick(); cpu_cli = 0; cpu_ack = 0;
    chk("R6 set wins", 16'(irq), 16'h0);
    cpu_cli = 1; tick(); cpu_cli = 0;
    wr(1, 8'h00); rd(0, v); chk("R7 zero write no effect", 16'(v), 16'h08);
    chk("R7 irq kept", 16'(irq), 16'h1);
    wr(1, 8'h08); rd(0, v); chk("R7 clear bit3", 16'(v), 16'h00);
    chk("R7 irq drops", 16'(irq), 16'h0);

    tmr1_uflow = 1; div_tick = 1; tick(); tmr1_uflow = 0; div_tick = 0;
    rd(0, v); chk("R2 timer1 and divider", 16'(v), 16'h30);
    wr(1, 8'hFF);
    rd(0, v); chk("R2 bits0/6 zero after clear", 16'(v), 16'h00);

    // R8 set wins over clear
    bus_wr = 1; bus_addr = 1; bus_wdata = 8'h10; tmr1_uflow = 1; tick();
    bus_wr = 0; tmr1_uflow = 0;
    rd(0, v); chk("R8 set beats clear", 16'(v), 16'h10);
    wr(1, 8'h10);

    // R3 8-pin port
    p0_is_input = 8'h0F;
    p0_pins[7] = 0; tick(4);
    rd(0, v); chk("R3 output-mode pin ignored", 16'(v), 16'h00);
    p0_pins[7] = 1; tick(4);
    p0_pins[0] = 0; tick(2);
    rd(0, v); chk("R3 not yet after two edges", 16'(v), 16'h00);
    tick(); rd(0, v); chk("R3 set on third edge", 16'(v), 16'h04);
    wr(1, 8'h04); p0_pins[0] = 1; tick(4);
    rd(0, v); chk("R3 rising edge ignored", 16'(v), 16'h00);

    // R4 5-pin port
    p1_pins[4] = 0; tick(3);
    rd(0, v); chk("R4 pin4 falling", 16'(v), 16'h02);
    p1_pins[4] = 1; wr(1, 8'h02); tick(3);
    p1_pins[0] = 0; tick(3);
    rd(0, v); chk("R4 pin0 falling", 16'(v), 16'h02);
    p1_pins[0] = 1; wr(1, 8'h02); tick(3);

    // R9 watchdog record
    wdt_event = 1; tick(); wdt_event = 0;
    rd(0, v); chk("R9 wdt set", 16'(v), 16'h80);
    wr(1, 8'h80); rd(0, v); chk("R9 locked clear ignored", 16'(v), 16'h80);
    wdt_unlock = 1; wr(1, 8'h80); wdt_unlock = 0;
    rd(0, v); chk("R9 unlocked clear", 16'(v), 16'h00);

    // R10 brown-out control bit
    wdt_event = 1; tick(); wdt_event = 0;
    wr(0, 8'hC1);
    rd(1, v); chk("R10 enable readback", 16'(v), 16'h80);
    chk("R10 pd_bor", 16'(pd_bor), 16'h1);
    chk("R10 no irq from bit7", 16'(irq), 16'h0);
    rd(0, v); chk("R12 status at addr0", 16'(v), 16'h80);

    // R11 vectors
    vec_reset = 0; vec_high = 0; #1 chk("R11 irq low", vec_addr, 16'hFFFE);
    vec_high = 1; #1 chk("R11 irq high", vec_addr, 16'hFFFF);
    vec_reset = 1; vec_high = 0; #1 chk("R11 reset low", vec_addr, 16'hFFFC);
    vec_high = 1; #1 chk("R11 reset high", vec_addr, 16'hFFFD);

    finish_run();
  end
endmodule